// File: doc/BRIEF.md
# Mode-Select ALU with Status Flags

This block is a purely combinational N-bit arithmetic/logic unit. It takes two operands, a carry-in bit and a three-bit operation select. The top select bit splits the operations into an arithmetic group and a logic group. The two lower bits pick one of four operations inside the chosen group.

In the arithmetic group the carry-in takes part in every operation. It can therefore increment a plain pass-through, complete a two's-complement subtraction, or cancel a decrement. Alongside the result the block produces four status flags:

- signed overflow
- carry-out
- negative
- zero

A datapath controller can use the flags for branch decisions. The block holds no state, so its outputs follow its inputs within the same clock period.

Top module: `mode_alu`

## Requirements
- R1: `sel_i[2]` picks the group: 0 selects the arithmetic operations and 1 selects the logic operations. `sel_i[1:0]` picks the operation within the group.
- R2: `sel_i = 3'b000` gives `res_o = a_i + cin_i` (modulo 2^W).
- R3: `sel_i = 3'b001` gives `res_o = a_i + b_i + cin_i`.
- R4: `sel_i = 3'b010` gives `res_o = a_i + ~b_i + cin_i`. With `cin_i = 1` this equals `a_i - b_i`.
- R5: `sel_i = 3'b011` gives `res_o = a_i - 1 + cin_i`. The operand added to `a_i` is all ones.
- R6: In the logic group, `sel_i[1:0]` of 00, 01, 10 and 11 gives AND, OR, XOR and bitwise NOT of `a_i`. `cin_i` has no effect in this group, and `b_i` has no effect under NOT.
- R7: In the arithmetic group, `c_o` is the carry out of the most significant bit of the W-bit addition.
- R8: In the arithmetic group, `v_o` is 1 exactly when the sum, read as signed two's complement, falls outside the range -2^(W-1) to 2^(W-1)-1.
- R9: In the logic group, `v_o` and `c_o` are both 0.
- R10: `n_o` equals bit W-1 of `res_o`.
- R11: `z_o` is 1 exactly when `res_o` is all zeros.
- R12: The block holds no state. A change on any input is seen on the outputs without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| cin_i | input | 1 | Carry-in, used by arithmetic operations only |
| sel_i | input | 3 | Bit 2 selects the group, bits 1:0 select the operation |
| res_o | output | W | Operation result |
| v_o | output | 1 | Signed overflow flag |
| c_o | output | 1 | Carry-out flag |
| n_o | output | 1 | Negative flag (result MSB) |
| z_o | output | 1 | Zero flag |

## Verification
Every result and flag is due in the same cycle as its stimulus, because no register lies between the inputs and the outputs. The bench therefore drives each input vector on a rising edge and samples on the following falling edge, half a period later. For R12 it also changes the operands between edges and samples one nanosecond later. The sweep covers every select value, every operand pair and both carry-in values at W = 4. Expected sums and overflow are computed in the bench with integer arithmetic and signed range checks, not with carry chains.

// File: rtl/mode_alu_pkg.sv
package mode_alu_pkg;

  typedef enum logic {
    GRP_ARITH = 1'b0,
    GRP_LOGIC = 1'b1
  } grp_e;

  typedef enum logic [1:0] {
    AR_INC = 2'b00,
    AR_ADD = 2'b01,
    AR_SUB = 2'b10,
    AR_DEC = 2'b11
  } arith_fn_e;

  typedef enum logic [1:0] {
    LG_AND = 2'b00,
    LG_OR  = 2'b01,
    LG_XOR = 2'b10,
    LG_NOT = 2'b11
  } logic_fn_e;

endpackage

// File: rtl/alu_arith.sv
module alu_arith
  import mode_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  arith_fn_e    fn_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         cmsb_o
);

  logic [W-1:0] addend;
  logic [W:0]   carry;

  // Second operand chosen before the adder
  always_comb begin
    case (fn_i)
      AR_INC:  addend = '0;
      AR_ADD:  addend = b_i;
      AR_SUB:  addend = ~b_i;
      default: addend = '1;
    endcase
  end

  assign carry[0] = cin_i;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum_o[i]   = a_i[i] ^ addend[i] ^ carry[i];
    assign carry[i+1] = (a_i[i] & addend[i]) | (a_i[i] & carry[i]) | (addend[i] & carry[i]);
  end

  assign cout_o = carry[W];
  assign cmsb_o = carry[W-1];

  always_comb begin
    if (fn_i == AR_SUB && cin_i)
      a_r4_sub_twos: assert (sum_o == W'(a_i - b_i));
    if (fn_i == AR_INC && !cin_i)
      a_r2_pass_plain: assert (sum_o == a_i && !cout_o);
    if (fn_i == AR_DEC && cin_i)
      a_r5_dec_cancel: assert (sum_o == a_i && cout_o);
    if (fn_i == AR_ADD)
      a_r3_full_sum: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i}));
  end

endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import mode_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic_fn_e    fn_i,
  output logic [W-1:0] res_o
);

  always_comb begin
    case (fn_i)
      LG_AND:  res_o = a_i & b_i;
      LG_OR:   res_o = a_i | b_i;
      LG_XOR:  res_o = a_i ^ b_i;
      default: res_o = ~a_i;
    endcase
  end

  always_comb begin
    if (fn_i == LG_XOR)
      a_r6_xor_undo: assert ((res_o ^ b_i) == a_i);
    if (fn_i == LG_AND)
      a_r6_and_subset: assert ((res_o & ~b_i) == '0 && (res_o & ~a_i) == '0);
  end

endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int W = 8
) (
  input  logic [W-1:0] res_i,
  input  logic         arith_i,
  input  logic         cout_i,
  input  logic         cmsb_i,
  output logic         v_o,
  output logic         c_o,
  output logic         n_o,
  output logic         z_o
);

  assign v_o = arith_i & (cmsb_i ^ cout_i);
  assign c_o = arith_i & cout_i;
  assign n_o = res_i[W-1];
  assign z_o = ~|res_i;

  always_comb begin
    if (z_o)
      a_r11_zero_not_neg: assert (!n_o);
  end

endmodule

// File: rtl/mode_alu.sv
module mode_alu
  import mode_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic [2:0]   sel_i,
  output logic [W-1:0] res_o,
  output logic         v_o,
  output logic         c_o,
  output logic         n_o,
  output logic         z_o
);

  localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};

  grp_e         grp;
  logic [W-1:0] arith_res;
  logic [W-1:0] logic_res;
  logic         arith_cout;
  logic         arith_cmsb;

  assign grp = grp_e'(sel_i[2]);

  alu_arith #(.W(W)) u_arith (
    .a_i    (a_i),
    .b_i    (b_i),
    .cin_i  (cin_i),
    .fn_i   (arith_fn_e'(sel_i[1:0])),
    .sum_o  (arith_res),
    .cout_o (arith_cout),
    .cmsb_o (arith_cmsb)
  );

  alu_logic #(.W(W)) u_logic (
    .a_i   (a_i),
    .b_i   (b_i),
    .fn_i  (logic_fn_e'(sel_i[1:0])),
    .res_o (logic_res)
  );

  assign res_o = (grp == GRP_ARITH) ? arith_res : logic_res;

  alu_flags #(.W(W)) u_flags (
    .res_i   (res_o),
    .arith_i (grp == GRP_ARITH),
    .cout_i  (arith_cout),
    .cmsb_i  (arith_cmsb),
    .v_o     (v_o),
    .c_o     (c_o),
    .n_o     (n_o),
    .z_o     (z_o)
  );

  always_comb begin
    if (sel_i[2])
      a_r9_logic_quiet: assert (!v_o && !c_o);
    if (sel_i == 3'b000 && v_o)
      a_r8_inc_overflow: assert (a_i == MAX_POS && cin_i);
  end

endmodule

// File: tb/mode_alu_tb_top.sv
`timescale 1ns/1ps
module mode_alu_tb_top;

  localparam int W = 4;
  localparam int M = (1 << W) - 1;

  logic         clk = 1'b0;
  logic [W-1:0] a, b;
  logic         cin;
  logic [2:0]   sel;
  logic [W-1:0] res;
  logic         v, c, n, z;
  int           n_checks = 0;
  int           n_fail = 0;
  bit           done = 1'b0;

  always #4 clk = ~clk;

  mode_alu #(.W(W)) dut_i (
    .a_i(a), .b_i(b), .cin_i(cin), .sel_i(sel),
    .res_o(res), .v_o(v), .c_o(c), .n_o(n), .z_o(z)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s sel=%0d a=%0d b=%0d cin=%0d actual=%0d expected=%0d",
               req, sel, a, b, cin, act, exp);
    end
  endtask

  function automatic int sx(input int x);
    return (x > (M >> 1)) ? x - (M + 1) : x;
  endfunction

  initial begin
    a = '0; b = '0; cin = 1'b0; sel = 3'b000;

    // Zero inputs give a zero result (R11)
    @(negedge clk);
    check(z == 1'b1, "R11 zero inputs", z, 1);
    check(res == '0, "R2 zero inputs", res, 0);

    // Same operands, group bit toggled (R1): 5+3=8 versus 5|3=7
    @(posedge clk); a = 5; b = 3; sel = 3'b001;
    @(negedge clk); check(res == 8, "R1 arith group", res, 8);
    @(posedge clk); sel = 3'b101;
    @(negedge clk); check(res == 7, "R1 logic group", res, 7);

    // Outputs follow inputs without an edge (R12)
    a = 9; b = 2; sel = 3'b010; cin = 1'b1;
    #1 check(res == 7, "R12 no clock needed", res, 7);

    // Exhaustive sweep
    for (int s = 0; s < 8; s++)
      for (int ai = 0; ai <= M; ai++)
        for (int bi = 0; bi <= M; bi++)
          for (int ci = 0; ci < 2; ci++) begin
            int beff, full, er, ev, ec, sum_s;
            string rq;
            @(posedge clk);
            sel = 3'(s); a = W'(ai); b = W'(bi); cin = ci[0];
            ev = 0; ec = 0; beff = 0;
            if (s < 4) begin
              case (s)
                0: begin beff = 0;        rq = "R2 a+cin"; end
                1: begin beff = bi;       rq = "R3 a+b+cin"; end
                2: begin beff = (~bi) & M; rq = "R4 a+~b+cin"; end
                default: begin beff = M;  rq = "R5 a-1+cin"; end
              endcase
              full = ai + beff + ci;
              er = full & M;
              ec = full >> W;
              sum_s = sx(ai) + sx(beff) + ci;
              ev = (sum_s > (M >> 1) || sum_s < -((M + 1) >> 1)) ? 1 : 0;
            end else begin
              case (s)
                4: er = ai & bi;
                5: er = ai | bi;
                6: er = ai ^ bi;
                default: er = (~ai) & M;
              endcase
              rq = "R6 logic op";
            end
            @(negedge clk);
            check(int'(res) == er, rq, res, er);
            if (s < 4) begin
              check(int'(c) == ec, "R7 carry", c, ec);
              check(int'(v) == ev, "R8 overflow", v, ev);
            end else begin
              check(v == 1'b0 && c == 1'b0, "R9 quiet flags", {v, c}, 0);
            end
            check(int'(n) == ((er >> (W - 1)) & 1), "R10 negative", n, (er >> (W - 1)) & 1);
            check(int'(z) == ((er == 0) ? 1 : 0), "R11 zero", z, (er == 0) ? 1 : 0);
          end

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule